// File: doc/BRIEF.md
# Four-Channel Thermal Protection Sequencer

This block is the digital supervisor for four independent high-side switch channels. Each channel has a command input and a junction temperature code. All channels share one case temperature code and one supply-undervoltage flag. The block drives one gate enable and one active-low fault status per channel. A commanded channel whose junction overheats is switched off. It is switched back on once the junction has cooled, which holds the junction inside a hysteresis band for as long as the overload lasts.

A channel counts as overloaded from its first junction trip until its command is removed. If the shared case temperature rises above a case limit, every overloaded channel is latched off. Channels that are not overloaded keep following their commands. Once the case has cooled below a lower reset limit, the latched channels become eligible to restart. A round-robin sequencer then re-enables them one at a time, with a fixed gap between consecutive restarts, so that their inrush currents never coincide. Current limiting, sensing and the other analog functions stay outside this block. Their effect arrives only through the temperature codes and the undervoltage flag.

Top module: `thermal_seq`

## Requirements
- R1: A channel whose command is high switches its gate enable off at the first clock edge where its junction code is strictly greater than TJ_TRIP (default 170). A code equal to TJ_TRIP does not trip.
- R2: A junction-tripped channel stays off until a clock edge where its junction code is strictly less than TJ_RESUME (default 135). A code equal to TJ_RESUME keeps it off. After that edge the gate enable follows the command again.
- R3: While the case code is strictly greater than CASE_TRIP (default 130), every overloaded channel with its command high is latched off at the next edge. This holds whether the channel is momentarily on or off. It stays off while the case code is not strictly less than CASE_RESUME (default 110), even if its junction has cooled.
- R4: A channel that is not overloaded is never latched by the case condition. Its gate enable equals its command in the same cycle.
- R5: After the case has cooled, latched channels restart one at a time. A restart takes effect two edges after the edge on which the case code is first seen below CASE_RESUME. Consecutive restarts are RESTART_GAP+1 edges apart (default gap 4). The next channel served is the first waiting channel after the one restarted last, in ascending index order with wrap-around. Channel 0 is first after reset.
- R6: stat_n[i] is 0 exactly while channel i is held off by a junction trip, a case latch or a pending restart. Otherwise it is 1.
- R7: While uv_flag is 1, every gate enable is 0 in the same cycle, whatever the commands are.
- R8: Dropping the command of a latched or waiting channel leaves the case protection at the next edge and clears its overloaded mark. Its status stays 0 until the junction code is below TJ_RESUME. A fresh command is then obeyed at once, even while the case is still hot.
- R9: A synchronous active-high reset clears every latch and overload mark and points the sequencer at channel 0. While rst is 1, all gate enables are 0 and all status lines are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_cmd | input | NUM_CH | Per-channel on command |
| junc_temp | input | NUM_CH x 8 | Per-channel junction temperature code, unsigned degrees C |
| case_temp | input | 8 | Shared case temperature code, unsigned degrees C |
| uv_flag | input | 1 | Supply undervoltage indication, forces all outputs off |
| gate_en | output | NUM_CH | Per-channel output stage enable |
| stat_n | output | NUM_CH | Per-channel overtemperature status, active low |

## Verification
The bench drives junction codes equal to each threshold to separate strict from non-strict compares. A design that used greater-or-equal would trip at exactly 170 or release at exactly 135. It holds the case code between its two limits with cool junctions, to catch a latch that releases on the junction reading or on the upper limit. It times two staggered restarts edge by edge, then runs a second round to confirm that the round-robin pointer rotates. A sequencer that restarted together, ignored the gap or always began at channel 0 would turn on the wrong channel in the wrong cycle. It also checks that a healthy channel keeps running through a case shutdown, and that a command dropped during a latch clears the overload mark, so that the next command is not latched again.

// File: rtl/thermal_seq_pkg.sv
package thermal_seq_pkg;

    localparam int TEMP_W = 8;

    typedef logic [TEMP_W-1:0] temp_t;

    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,   // follows command
        CH_JHOT  = 2'd1,   // off on junction trip
        CH_CLAT  = 2'd2,   // off, latched by case
        CH_QUEUE = 2'd3    // case cooled, waiting for restart slot
    } ch_state_e;

    function automatic logic above(input temp_t t, input int lim);
        return int'(t) > lim;
    endfunction

    function automatic logic below(input temp_t t, input int lim);
        return int'(t) < lim;
    endfunction

endpackage

// File: rtl/thermal_seq_chan.sv
module thermal_seq_chan
    import thermal_seq_pkg::*;
#(
    parameter int TJ_TRIP   = 170,
    parameter int TJ_RESUME = 135
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd,
    input  temp_t tj,
    input  logic  case_hot,
    input  logic  case_cool,
    input  logic  grant,
    output logic  req,
    output logic  run_ok,
    output logic  ovt
);

    ch_state_e state;
    logic      ovl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_RUN;
            ovl   <= 1'b0;
        end else begin
            unique case (state)
                CH_RUN: begin
                    if (!cmd) begin
                        ovl <= 1'b0;
                    end else if (ovl && case_hot) begin
                        state <= CH_CLAT;
                    end else if (above(tj, TJ_TRIP)) begin
                        state <= CH_JHOT;
                        ovl   <= 1'b1;
                    end
                end
                CH_JHOT: begin
                    if (!cmd) ovl <= 1'b0;
                    if (cmd && ovl && case_hot) state <= CH_CLAT;
                    else if (below(tj, TJ_RESUME)) state <= CH_RUN;
                end
                CH_CLAT: begin
                    if (!cmd) begin
                        state <= CH_JHOT;
                        ovl   <= 1'b0;
                    end else if (case_cool) begin
                        state <= CH_QUEUE;
                    end
                end
                CH_QUEUE: begin
                    if (!cmd) begin
                        state <= CH_JHOT;
                        ovl   <= 1'b0;
                    end else if (grant) begin
                        state <= CH_RUN;
                    end
                end
                default: state <= CH_RUN;
            endcase
        end
    end

    assign req    = (state == CH_QUEUE) && cmd;
    assign run_ok = (state == CH_RUN);
    assign ovt    = (state != CH_RUN);

    // R3: a latched channel holds while the case has not cooled
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == CH_CLAT && cmd && !case_cool) |=> (state == CH_CLAT));

    // R5: a waiting channel never restarts without its slot
    p_wait_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (state == CH_QUEUE && cmd && !grant) |=> (state == CH_QUEUE));

    // R2: a junction-off channel stays off while not below the resume code
    p_jhot_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == CH_JHOT && !below(tj, TJ_RESUME) && !(cmd && ovl && case_hot))
        |=> (state == CH_JHOT));

endmodule

// File: rtl/thermal_seq_restart_arb.sv
module thermal_seq_restart_arb #(
    parameter int NUM_CH      = 4,
    parameter int RESTART_GAP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] grant
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W = (RESTART_GAP > 0) ? $clog2(RESTART_GAP + 1) : 1;

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] pick;
    logic             found;
    logic [CNT_W-1:0] gap_q;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int off = 1; off <= NUM_CH; off++) begin
            int idx;
            idx = int'(last_q) + off;
            if (idx >= NUM_CH) idx = idx - NUM_CH;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IDX_W'(idx);
            end
        end
        grant = '0;
        if (found && gap_q == '0) grant[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDX_W'(NUM_CH - 1);
            gap_q  <= '0;
        end else if (|grant) begin
            last_q <= pick;
            gap_q  <= CNT_W'(RESTART_GAP);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    // R5: at most one restart per edge
    p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5: a slot only goes to a channel that asked for it
    p_grant_req_r5: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    generate
        if (RESTART_GAP > 0) begin : g_gap_chk
            // R5: no restart on the edge right after another
            p_gap_r5: assert property (@(posedge clk) disable iff (rst)
                (|grant) |=> (grant == '0));
        end
    endgenerate

endmodule

// File: rtl/thermal_seq.sv
module thermal_seq
    import thermal_seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int TJ_TRIP     = 170,
    parameter int TJ_RESUME   = 135,
    parameter int CASE_TRIP   = 130,
    parameter int CASE_RESUME = 110,
    parameter int RESTART_GAP = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             chan_cmd,
    input  logic [NUM_CH-1:0][TEMP_W-1:0] junc_temp,
    input  logic [TEMP_W-1:0]             case_temp,
    input  logic                          uv_flag,
    output logic [NUM_CH-1:0]             gate_en,
    output logic [NUM_CH-1:0]             stat_n
);

    logic              case_hot;
    logic              case_cool;
    logic [NUM_CH-1:0] req;
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] run_ok;
    logic [NUM_CH-1:0] ovt;

    assign case_hot  = above(case_temp, CASE_TRIP);
    assign case_cool = below(case_temp, CASE_RESUME);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            thermal_seq_chan #(
                .TJ_TRIP   (TJ_TRIP),
                .TJ_RESUME (TJ_RESUME)
            ) u_chan (
                .clk       (clk),
                .rst       (rst),
                .cmd       (chan_cmd[i]),
                .tj        (junc_temp[i]),
                .case_hot  (case_hot),
                .case_cool (case_cool),
                .grant     (grant[i]),
                .req       (req[i]),
                .run_ok    (run_ok[i]),
                .ovt       (ovt[i])
            );
        end
    endgenerate

    thermal_seq_restart_arb #(
        .NUM_CH      (NUM_CH),
        .RESTART_GAP (RESTART_GAP)
    ) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .grant (grant)
    );

    assign gate_en = (rst || uv_flag) ? '0 : (chan_cmd & run_ok);
    assign stat_n  = rst ? '1 : ~ovt;

    // R7: undervoltage keeps every output stage off
    p_uv_off_r7: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> (gate_en == '0));

    // R6: an enabled channel never reports a fault
    p_on_no_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (gate_en & ~stat_n) == '0);

    // R9: reset leaves outputs off and status released
    p_reset_state_r9: assert property (@(posedge clk)
        $past(rst) |-> (stat_n == '1));

endmodule

// File: tb/thermal_seq_test.sv
module thermal_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int GAP = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    chan_cmd;
    logic [N-1:0][7:0] junc_temp;
    logic [7:0]      case_temp;
    logic            uv_flag;
    logic [N-1:0]    gate_en;
    logic [N-1:0]    stat_n;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_seq #(.NUM_CH(N), .RESTART_GAP(GAP)) uut (
        .clk       (clk),
        .rst       (rst),
        .chan_cmd  (chan_cmd),
        .junc_temp (junc_temp),
        .case_temp (case_temp),
        .uv_flag   (uv_flag),
        .gate_en   (gate_en),
        .stat_n    (stat_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        chan_cmd = '0;
        for (int i = 0; i < N; i++) junc_temp[i] = 8'd60;
        case_temp = 8'd60;
        uv_flag = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        chan_cmd = '1;
        step(2);
        chk("R9 gate off in reset", 32'(gate_en), 32'h0);
        chk("R9 status high in reset", 32'(stat_n), 32'hF);
        rst = 1'b0;
        chan_cmd = '0;
        step(1);
    endtask

    task automatic t_follow();
        do_reset();
        chan_cmd = 4'b1010;
        #1 chk("R4 follow 1010", 32'(gate_en), 32'hA);
        step(1);
        chan_cmd = 4'b0111;
        #1 chk("R4 follow 0111", 32'(gate_en), 32'h7);
        chk("R6 status idle", 32'(stat_n), 32'hF);
        step(1);
    endtask

    task automatic t_junction();
        do_reset();
        chan_cmd = 4'b0001;
        junc_temp[0] = 8'd170;
        step(1);
        chk("R1 equal trip code no trip", 32'(gate_en), 32'h1);
        junc_temp[0] = 8'd171;
        step(1);
        chk("R1 trip off", 32'(gate_en), 32'h0);
        chk("R6 status low on trip", 32'(stat_n), 32'hE);
        junc_temp[0] = 8'd135;
        step(2);
        chk("R2 equal resume code holds off", 32'(gate_en), 32'h0);
        junc_temp[0] = 8'd134;
        step(1);
        chk("R2 resumed", 32'(gate_en), 32'h1);
        chk("R6 status released", 32'(stat_n), 32'hF);
        junc_temp[0] = 8'd180;
        step(1);
        chk("R2 cycles off again", 32'(gate_en), 32'h0);
        junc_temp[0] = 8'd100;
        step(1);
    endtask

    task automatic t_case();
        do_reset();
        chan_cmd = 4'b0111;
        junc_temp[0] = 8'd180;
        junc_temp[1] = 8'd180;
        step(1);
        junc_temp[0] = 8'd100;
        junc_temp[1] = 8'd150;
        step(1);
        chk("R2 ch0 back on, ch1 held", 32'(gate_en), 32'h5);
        case_temp = 8'd131;
        step(1);
        chk("R3 overloaded latched, R4 ch2 runs", 32'(gate_en), 32'h4);
        chk("R6 latched status", 32'(stat_n), 32'hC);
        junc_temp[1] = 8'd100;
        case_temp = 8'd110;
        step(3);
        chk("R3 hold between case limits", 32'(gate_en), 32'h4);
        case_temp = 8'd109;
        step(1);
        chk("R5 not yet restarted", 32'(gate_en), 32'h4);
        step(1);
        chk("R5 first restart ch0", 32'(gate_en), 32'h5);
        step(GAP);
        chk("R5 gap holds ch1", 32'(gate_en), 32'h5);
        chk("R6 waiting status low", 32'(stat_n), 32'hD);
        step(1);
        chk("R5 second restart ch1", 32'(gate_en), 32'h7);
    endtask

    task automatic t_rotate();
        do_reset();
        chan_cmd = 4'b1110;
        junc_temp[2] = 8'd180;
        step(1);
        junc_temp[2] = 8'd100;
        step(1);
        case_temp = 8'd131;
        step(1);
        case_temp = 8'd100;
        step(2);
        chk("R5 round one ch2", 32'(gate_en), 32'hE);
        chan_cmd = 4'b1010;
        junc_temp[1] = 8'd180;
        junc_temp[3] = 8'd180;
        step(1);
        junc_temp[1] = 8'd100;
        junc_temp[3] = 8'd100;
        step(GAP + 1);
        case_temp = 8'd131;
        step(1);
        chk("R3 both latched", 32'(gate_en), 32'h0);
        case_temp = 8'd100;
        step(2);
        chk("R5 rotation serves ch3 first", 32'(gate_en), 32'h8);
        step(GAP + 1);
        chk("R5 then ch1", 32'(gate_en), 32'hA);
    endtask

    task automatic t_drop();
        do_reset();
        chan_cmd = 4'b0001;
        junc_temp[0] = 8'd180;
        step(1);
        case_temp = 8'd140;
        step(1);
        chan_cmd = 4'b0000;
        step(1);
        chk("R8 status low while hot", 32'(stat_n), 32'hE);
        junc_temp[0] = 8'd100;
        step(1);
        chk("R8 status high after cooling", 32'(stat_n), 32'hF);
        chan_cmd = 4'b0001;
        step(2);
        chk("R8 recommand obeyed with hot case", 32'(gate_en), 32'h1);
    endtask

    task automatic t_uv();
        do_reset();
        chan_cmd = 4'b1111;
        uv_flag = 1'b1;
        #1 chk("R7 undervoltage forces off", 32'(gate_en), 32'h0);
        step(1);
        uv_flag = 1'b0;
        #1 chk("R7 outputs return", 32'(gate_en), 32'hF);
        step(1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        chan_cmd = 4'b0001;
        junc_temp[0] = 8'd180;
        step(1);
        case_temp = 8'd140;
        junc_temp[0] = 8'd100;
        step(1);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        step(2);
        chk("R9 reset cleared latch", 32'(gate_en), 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        chan_cmd = '0;
        for (int i = 0; i < N; i++) junc_temp[i] = 8'd60;
        case_temp = 8'd60;
        uv_flag = 1'b0;
        t_reset();
        t_follow();
        t_junction();
        t_case();
        t_rotate();
        t_drop();
        t_uv();
        t_reset_clears();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule